// File: doc/BRIEF.md
# Paged Write Buffer with Timed Commit

This block sits behind a two-wire serial memory protocol engine and turns the data bytes of one write transaction into array updates. The protocol engine announces a new write with a starting word address, then strobes each received data byte. Bytes are held in a page buffer that is one page wide. The buffer pointer moves only inside the page that the starting address selects. If more bytes arrive than the page holds, the newest bytes replace the oldest ones.

Nothing reaches the storage array while bytes are arriving. A Stop indication commits the buffered bytes and starts a timed internal write cycle. The busy flag is high for the whole cycle, and the block ignores the protocol engine for that time. An abort indication (for example a repeated Start) discards the buffer. A per-position protection mask removes positions from the commit. A supply-low input blocks all array writes. A small synchronous RAM model stands in for the array, and it has a registered read port for observation.

Top module: `page_commit_buffer`

## Requirements
- R1: A page holds 16 bytes and begins at an address that is a multiple of 16. The byte loaded at buffer position p is written to array address {start_addr[7:4], p}. The first byte goes to position start_addr[3:0]. Each later byte goes to the next position modulo 16, so the writes wrap to the start of the same page.
- R2: When more than 16 bytes arrive before Stop, each position keeps the last byte loaded into it. The array therefore receives the final 16 bytes of the transaction.
- R3: No array write strobe occurs while bytes are being loaded. Array writes happen only inside the write cycle that a Stop starts.
- R4: A Stop after at least one loaded byte raises busy on the next clock. Busy then stays high for exactly WR_CYCLES clocks.
- R5: An abort discards the buffered bytes. No array write follows, busy stays low, and a later Stop with no new bytes does nothing.
- R6: A Stop in a transaction that loaded no data bytes leaves busy low and writes nothing.
- R7: Only positions loaded in the current transaction are written. All other addresses of the page keep their previous contents.
- R8: When bit p of prot_mask is 1 at Stop, position p is not written. The write cycle still runs its full length if any byte was loaded, even when every loaded position is protected.
- R9: If supply_low is high at Stop, there is no write and no busy. While supply_low is high during a write cycle, no array write strobe occurs, but busy still lasts its full length.
- R10: While busy is high, txn_start, byte_valid, stop_seen and abort are ignored. Bytes sent during busy are never written, and a Stop sent during busy starts no further cycle.
- R11: While reset is asserted, and right after it is released, busy and arr_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Opens a write transaction and loads start_addr |
| start_addr | input | ADDR_W | Starting word address of the transaction |
| byte_valid | input | 1 | One received data byte on byte_data |
| byte_data | input | DATA_W | Data byte to buffer |
| stop_seen | input | 1 | Stop condition: commit the buffer |
| abort | input | 1 | Discard the buffer without writing |
| prot_mask | input | 16 | Per-position write protection, sampled at Stop |
| supply_low | input | 1 | Supply-low indication; blocks array writes |
| rd_addr | input | ADDR_W | Observation read address |
| rd_data | output | DATA_W | Array data at rd_addr, one clock later |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the block with WR_CYCLES set to 40 instead of a multi-millisecond count. This makes a busy window only a little longer than the 16-clock commit sweep, so the bench can count busy lengths, run many write cycles, and send traffic during busy within a short run. The address and page widths keep their defaults. Wrapping inside a 16-byte page, a 20-byte overflow and protection of single positions are therefore tested on the real page geometry.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_BUSY = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/pcb_array.sv
module pcb_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= cells_q[raddr];
  end
endmodule

// File: rtl/pcb_page_buf.sv
module pcb_page_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold,
  input  logic                     txn_start,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic                     byte_valid,
  input  logic [DATA_W-1:0]        byte_data,
  input  logic                     stop_seen,
  input  logic                     abort,
  input  logic [PAGE_W-1:0]        rd_pos,
  output logic [DATA_W-1:0]        rd_byte,
  output logic [(1<<PAGE_W)-1:0]   loaded,
  output logic [ADDR_W-PAGE_W-1:0] page
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0]     ptr_q, ptr_d;
  logic [TAG_W-1:0]      page_q, page_d;
  logic [PAGE_BYTES-1:0] loaded_q, loaded_d;
  logic [PAGE_BYTES-1:0] slot_we;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic                  accept;

  assign accept = !hold;

  always_comb begin
    ptr_d    = ptr_q;
    page_d   = page_q;
    loaded_d = loaded_q;
    slot_we  = '0;
    if (accept) begin
      if (txn_start) begin
        ptr_d    = start_addr[PAGE_W-1:0];
        page_d   = start_addr[ADDR_W-1:PAGE_W];
        loaded_d = '0;
      end else if (abort || stop_seen) begin
        loaded_d = '0;
      end else if (byte_valid) begin
        slot_we[ptr_q]  = 1'b1;
        loaded_d[ptr_q] = 1'b1;
        ptr_d           = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      page_q   <= '0;
      loaded_q <= '0;
    end else begin
      ptr_q    <= ptr_d;
      page_q   <= page_d;
      loaded_q <= loaded_d;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (slot_we[i]) slot_q[i] <= byte_data;
    end
  end

  assign rd_byte = slot_q[rd_pos];
  assign loaded  = loaded_q;
  assign page    = page_q;

  // R1
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_start && accept) |=> $stable(page_q));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(loaded_q));
endmodule

// File: rtl/pcb_commit_ctl.sv
module pcb_commit_ctl
  import pcb_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_seen,
  input  logic                   abort,
  input  logic                   supply_low,
  input  logic [(1<<PAGE_W)-1:0] loaded,
  input  logic [(1<<PAGE_W)-1:0] prot_mask,
  output logic                   busy,
  output logic [PAGE_W-1:0]      pos,
  output logic                   we
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  ctl_state_e            state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [PAGE_BYTES-1:0] elig_q, elig_d;
  logic                  launch, in_sweep;

  assign launch = stop_seen && !abort && (|loaded) && !supply_low;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    elig_d  = elig_q;
    case (state_q)
      CTL_IDLE: begin
        if (launch) begin
          state_d = CTL_BUSY;
          cnt_d   = '0;
          elig_d  = loaded & ~prot_mask;
        end
      end
      CTL_BUSY: begin
        if (cnt_q == CNT_W'(WR_CYCLES - 1)) begin
          state_d = CTL_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      cnt_q   <= '0;
      elig_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      elig_q  <= elig_d;
    end
  end

  assign busy     = (state_q == CTL_BUSY);
  assign in_sweep = (cnt_q < CNT_W'(PAGE_BYTES));
  assign pos      = cnt_q[PAGE_W-1:0];
  assign we       = busy && in_sweep && elig_q[pos] && !supply_low;

  // R4
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CNT_W'(WR_CYCLES)));

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && abort) |=> !busy);
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 625000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txn_start,
  input  logic [ADDR_W-1:0]      start_addr,
  input  logic                   byte_valid,
  input  logic [DATA_W-1:0]      byte_data,
  input  logic                   stop_seen,
  input  logic                   abort,
  input  logic [(1<<PAGE_W)-1:0] prot_mask,
  input  logic                   supply_low,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   arr_we,
  output logic [ADDR_W-1:0]      arr_addr,
  output logic [DATA_W-1:0]      arr_wdata,
  output logic                   busy
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;

  logic [PAGE_BYTES-1:0] loaded;
  logic [TAG_W-1:0]      page;
  logic [PAGE_W-1:0]     pos;
  logic                  we;

  pcb_page_buf #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (busy),
    .txn_start  (txn_start),
    .start_addr (start_addr),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .stop_seen  (stop_seen),
    .abort      (abort),
    .rd_pos     (pos),
    .rd_byte    (arr_wdata),
    .loaded     (loaded),
    .page       (page)
  );

  pcb_commit_ctl #(
    .PAGE_W    (PAGE_W),
    .WR_CYCLES (WR_CYCLES)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_seen  (stop_seen),
    .abort      (abort),
    .supply_low (supply_low),
    .loaded     (loaded),
    .prot_mask  (prot_mask),
    .busy       (busy),
    .pos        (pos),
    .we         (we)
  );

  assign arr_we   = we;
  assign arr_addr = {page, pos};

  pcb_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_addr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R3
  commit_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
endmodule

// File: tb/page_commit_buffer_test.sv
module page_commit_buffer_test;
  localparam int WR = 40;

  typedef struct packed {
    logic [7:0]  addr;
    logic [5:0]  n;
    logic [7:0]  seed;
    logic [15:0] prot;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{addr: 8'h20, n: 6'd16, seed: 8'h00, prot: 16'h0000},
    '{addr: 8'h27, n: 6'd1,  seed: 8'hA0, prot: 16'h0000},
    '{addr: 8'h35, n: 6'd16, seed: 8'h10, prot: 16'h0000},
    '{addr: 8'h4C, n: 6'd6,  seed: 8'h50, prot: 16'h0000},
    '{addr: 8'h60, n: 6'd20, seed: 8'h80, prot: 16'h0000},
    '{addr: 8'h70, n: 6'd16, seed: 8'h30, prot: 16'h0000},
    '{addr: 8'h72, n: 6'd5,  seed: 8'hC0, prot: 16'h0008}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        txn_start, byte_valid, stop_seen, abort, supply_low;
  logic [7:0]  start_addr, byte_data, rd_addr, rd_data, arr_addr, arr_wdata;
  logic [15:0] prot_mask;
  logic        arr_we, busy;

  int total = 0;
  int failed = 0;
  logic [7:0] model [256];
  bit         known [256];

  always #4 clk = ~clk;

  page_commit_buffer #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_seen(stop_seen),
    .abort(abort), .prot_mask(prot_mask), .supply_low(supply_low),
    .rd_addr(rd_addr), .rd_data(rd_data), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bytes(input logic [7:0] addr, input int n, input logic [7:0] seed,
                            output bit we_seen);
    we_seen = 1'b0;
    @(negedge clk); txn_start = 1'b1; start_addr = addr;
    @(negedge clk); txn_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1; byte_data = seed + 8'(k);
      @(negedge clk);
      if (arr_we) we_seen = 1'b1;
    end
    byte_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic model_commit(input logic [7:0] addr, input int n, input logic [7:0] seed,
                              input logic [15:0] prot);
    logic [7:0] pd [16];
    bit         pl [16];
    for (int p = 0; p < 16; p++) begin pl[p] = 1'b0; pd[p] = 8'h00; end
    for (int k = 0; k < n; k++) begin
      int pp;
      pp = (int'(addr[3:0]) + k) % 16;
      pd[pp] = seed + 8'(k);
      pl[pp] = 1'b1;
    end
    for (int p = 0; p < 16; p++) begin
      if (pl[p] && !prot[p]) begin
        model[{addr[7:4], 4'(p)}] = pd[p];
        known[{addr[7:4], 4'(p)}] = 1'b1;
      end
    end
  endtask

  task automatic check_page(input logic [3:0] pg, input string tag);
    logic [7:0] d;
    for (int p = 0; p < 16; p++) begin
      if (known[{pg, 4'(p)}]) begin
        read_byte({pg, 4'(p)}, d);
        chk(d === model[{pg, 4'(p)}], tag, d, model[{pg, 4'(p)}]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int  n;
    bit  we_seen;
    for (int a = 0; a < 256; a++) known[a] = 1'b0;
    rst_n = 1'b0; txn_start = 0; byte_valid = 0; stop_seen = 0; abort = 0;
    supply_low = 0; start_addr = 0; byte_data = 0; rd_addr = 0; prot_mask = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    chk(arr_we == 1'b0, "R11 arr_we in reset", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && arr_we == 1'b0, "R11 after release", {busy, arr_we}, 0);

    // Table walk: R1 R2 R3 R4 R7 R8
    for (int v = 0; v < 7; v++) begin
      prot_mask = VECS[v].prot;
      send_bytes(VECS[v].addr, int'(VECS[v].n), VECS[v].seed, we_seen);
      chk(!we_seen, "R3 no write while loading", we_seen, 0);
      pulse_stop();
      count_busy(n);
      chk(n == WR, "R4 busy length", n, WR);
      model_commit(VECS[v].addr, int'(VECS[v].n), VECS[v].seed, VECS[v].prot);
      check_page(VECS[v].addr[7:4], "R1 R2 R7 R8 page data");
    end
    prot_mask = 16'h0000;

    // R6 stop without data bytes
    send_bytes(8'h20, 0, 8'h00, we_seen);
    pulse_stop();
    chk(busy == 1'b0, "R6 no busy without bytes", busy, 0);
    check_page(4'h2, "R6 array unchanged");

    // R5 abort discards
    send_bytes(8'h20, 3, 8'h55, we_seen);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(busy == 1'b0, "R5 no busy after abort", busy, 0);
    pulse_stop();
    chk(busy == 1'b0, "R5 later stop inert", busy, 0);
    check_page(4'h2, "R5 array unchanged");

    // R9 supply low at stop
    supply_low = 1'b1;
    send_bytes(8'h35, 2, 8'hEE, we_seen);
    pulse_stop();
    chk(busy == 1'b0, "R9 no busy under supply low", busy, 0);
    supply_low = 1'b0;
    check_page(4'h3, "R9 array unchanged");

    // R9 supply low during the cycle
    send_bytes(8'h40, 4, 8'hDD, we_seen);
    pulse_stop();
    supply_low = 1'b1;
    count_busy(n);
    supply_low = 1'b0;
    chk(n == WR, "R9 busy full under supply low", n, WR);
    check_page(4'h4, "R9 strobes suppressed");

    // R8 all loaded positions protected
    prot_mask = 16'hFFFF;
    send_bytes(8'h60, 3, 8'h11, we_seen);
    pulse_stop();
    count_busy(n);
    chk(n == WR, "R8 cycle runs when all protected", n, WR);
    prot_mask = 16'h0000;
    check_page(4'h6, "R8 array unchanged");

    // R10 traffic during busy is ignored
    send_bytes(8'h50, 2, 8'h77, we_seen);
    pulse_stop();
    model_commit(8'h50, 2, 8'h77, 16'h0000);
    send_bytes(8'h58, 3, 8'h99, we_seen);
    pulse_stop();
    count_busy(n);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 stop during busy ignored", busy, 0);
    pulse_stop();
    chk(busy == 1'b0, "R10 bytes during busy not buffered", busy, 0);
    check_page(4'h5, "R10 page data");
    begin
      logic [7:0] d0, d1;
      read_byte(8'h58, d0);
      read_byte(8'h5C, d1);
      chk(!known[8'h58] || d0 === model[8'h58], "R10 no write at 58", d0, model[8'h58]);
      chk(!known[8'h5C] || d1 === model[8'h5C], "R10 no write at 5C", d1, model[8'h5C]);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule